// File: doc/BRIEF.md
# Pin Bank Controller with Edge Capture

This block runs a bank of general-purpose pins from a small 32-bit register bus. The bus has an address, a write enable, write data and a combinational read-data return. Each pin has an output latch that drives its pad and a direction bit that drives the pad's output enable. The live pad level can be read back through a two-flop synchronizer.

The output latch is never written directly. Software turns pins on through a write-one-to-set register and off through a write-one-to-clear register, so no read-modify-write is needed and neighbouring pins are not disturbed. Rising and falling transitions each have their own per-pin enable. A detected edge sets a sticky status bit, which software clears by writing a one to it. A single level interrupt stays high while any status bit is set, and there is no separate mask.

Pin n lives in word n/32 at bit n%32. Each register kind occupies two consecutive 32-bit words, and each kind starts at a byte offset of 8 × its kind index.

Top module: `pinbank_gpio`

## Requirements
- R1: Register kinds decode from address bits [5:3]: 0 pad level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status. Address bit 2 selects the word, which covers pins 0–31 or 32–63, and bits [1:0] are ignored.
- R2: Writing a word of the set register (0x10/0x14) forces high the output latch bits written as 1. Bits written as 0 are unchanged. Reads of the set and clear registers return the latch, and `pad_out` mirrors the latch.
- R3: Writing a word of the clear register (0x18/0x1C) forces low the latch bits written as 1, and leaves all other bits unchanged.
- R4: The direction register (0x08/0x0C) is plain read-write. A 1 makes the pin an output, and `pad_oe` mirrors the register.
- R5: The pad level register (0x00/0x04) returns `pad_in` after two synchronizer flops, whatever the direction. Writes to it have no effect.
- R6: When a pin's rising-enable bit (0x20/0x24) is set, a 0→1 change of its synchronized level sets its status bit. The bit is readable on the third rising clock edge after the pad changes.
- R7: When a pin's falling-enable bit (0x28/0x2C) is set, a 1→0 change of its synchronized level sets its status bit with the same latency. With both enables set, either edge is captured.
- R8: Status bits (0x30/0x34) are write-one-to-clear. Writing 0 to a bit leaves it unchanged, and a set bit stays set until it is cleared.
- R9: If an edge is detected in the same cycle as a clearing write to its status bit, the bit stays set.
- R10: `irq` is high exactly while any status bit in either word is set. It can fall only after a bus write.
- R11: Reset clears every register, so all pins start as inputs with the latch low, edges disabled, no status and `irq` low.
- R12: Addresses 0x38 and above read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe, acts on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 64 | Asynchronous pad levels |
| pad_out | output | 64 | Output latch values |
| pad_oe | output | 64 | Pad output enables, 1 = drive |
| irq | output | 1 | Level interrupt, any status pending |

## Verification
The status assertions assume that `pad_in` may change at any time but is only counted once it has passed the synchronizer. They also assume that a bus write reaches exactly one register word per cycle. The bench therefore changes pads only on falling clock edges and holds each level for at least three cycles, so every transition gives exactly one detection. Bus writes are one cycle wide. One directed case places a clearing write on the very edge where a new detection lands, to exercise the precedence rule.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
   localparam int KIND_W = 3;

   typedef enum logic [KIND_W-1:0] {
      K_LEVEL = 3'd0,
      K_DIR   = 3'd1,
      K_SET   = 3'd2,
      K_CLR   = 3'd3,
      K_RISE  = 3'd4,
      K_FALL  = 3'd5,
      K_STAT  = 3'd6,
      K_RSVD  = 3'd7
   } reg_kind_e;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
   parameter int W      = 64,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pinbank_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] pipe_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
      end else begin
         pipe_q[0] <= din;
         for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      end
   end

   assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/pinbank_outbank.sv
module pinbank_outbank #(
   parameter int NPINS = 64,
   parameter int DW    = 32,
   localparam int NW     = NPINS / DW,
   localparam int WSEL_W = $clog2(NW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_we,
   input  logic              clr_we,
   input  logic              dir_we,
   input  logic [WSEL_W-1:0] wr_word,
   input  logic [DW-1:0]     wdata,
   output logic [NPINS-1:0]  latch,
   output logic [NPINS-1:0]  dir
);
   logic [DW-1:0]    latch_q [NW];
   logic [DW-1:0]    dir_q   [NW];
   logic [NPINS-1:0] set_mask;
   logic [NPINS-1:0] clr_mask;

   for (genvar w = 0; w < NW; w++) begin : g_word
      logic hit;
      assign hit = (wr_word == WSEL_W'(w));
      assign set_mask[w*DW +: DW] = (set_we && hit) ? wdata : '0;
      assign clr_mask[w*DW +: DW] = (clr_we && hit) ? wdata : '0;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            latch_q[w] <= '0;
            dir_q[w]   <= '0;
         end else begin
            latch_q[w] <= (latch_q[w] | set_mask[w*DW +: DW]) & ~clr_mask[w*DW +: DW];
            if (dir_we && hit) dir_q[w] <= wdata;
         end
      end

      assign latch[w*DW +: DW] = latch_q[w];
      assign dir[w*DW +: DW]   = dir_q[w];
   end

   // set and clear strobes seen against the latch one cycle later
   assert_set_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((latch & $past(set_mask)) == $past(set_mask)));
   assert_clear_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((latch & $past(clr_mask)) == '0));
   assert_untouched_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((latch ^ $past(latch)) & ~($past(set_mask) | $past(clr_mask))) == '0));
endmodule

// File: rtl/pinbank_edge.sv
module pinbank_edge #(
   parameter int NPINS = 64,
   parameter int DW    = 32,
   localparam int NW     = NPINS / DW,
   localparam int WSEL_W = $clog2(NW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPINS-1:0]  level,
   input  logic              rise_we,
   input  logic              fall_we,
   input  logic              ack_we,
   input  logic [WSEL_W-1:0] wr_word,
   input  logic [DW-1:0]     wdata,
   output logic [NPINS-1:0]  rise_en,
   output logic [NPINS-1:0]  fall_en,
   output logic [NPINS-1:0]  status
);
   logic [DW-1:0]    rise_q [NW];
   logic [DW-1:0]    fall_q [NW];
   logic [DW-1:0]    stat_q [NW];
   logic [NPINS-1:0] prev_q;
   logic [NPINS-1:0] hit_evt;
   logic [NPINS-1:0] ack_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   for (genvar w = 0; w < NW; w++) begin : g_word
      logic hit;
      assign hit = (wr_word == WSEL_W'(w));
      assign ack_mask[w*DW +: DW] = (ack_we && hit) ? wdata : '0;
      assign hit_evt[w*DW +: DW] =
           ( level[w*DW +: DW] & ~prev_q[w*DW +: DW] & rise_q[w])
         | (~level[w*DW +: DW] &  prev_q[w*DW +: DW] & fall_q[w]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rise_q[w] <= '0;
            fall_q[w] <= '0;
            stat_q[w] <= '0;
         end else begin
            if (rise_we && hit) rise_q[w] <= wdata;
            if (fall_we && hit) fall_q[w] <= wdata;
            // a fresh detection takes precedence over an acknowledge
            stat_q[w] <= (stat_q[w] & ~ack_mask[w*DW +: DW]) | hit_evt[w*DW +: DW];
         end
      end

      assign rise_en[w*DW +: DW] = rise_q[w];
      assign fall_en[w*DW +: DW] = fall_q[w];
      assign status[w*DW +: DW]  = stat_q[w];
   end

   assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_evt != '0) |=> ((status & $past(hit_evt)) == $past(hit_evt)));
   assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & $past(status) & ~$past(ack_mask)) == ($past(status) & ~$past(ack_mask))));
   assert_status_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & ~$past(status) & ~$past(hit_evt)) == '0));
endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio
   import pinbank_pkg::*;
#(
   parameter int NPINS  = 64,
   parameter int DW     = 32,
   parameter int AW     = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    bus_addr,
   input  logic             bus_we,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic [NPINS-1:0] pad_in,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe,
   output logic             irq
);
   localparam int NW       = NPINS / DW;
   localparam int WSEL_W   = $clog2(NW);
   localparam int KIND_LSB = 2 + WSEL_W;
   localparam int TOP_LSB  = KIND_LSB + KIND_W;

   generate
      if (NPINS % DW != 0) begin : g_bad_split
         $error("pinbank_gpio: NPINS must be a multiple of DW");
      end
      if (NW < 2 || (NW & (NW - 1)) != 0) begin : g_bad_words
         $error("pinbank_gpio: word count must be a power of two, at least 2");
      end
      if (AW < TOP_LSB) begin : g_bad_aw
         $error("pinbank_gpio: AW too narrow for the register map");
      end
   endgenerate

   reg_kind_e         kind;
   logic [WSEL_W-1:0] word;
   logic              addr_ok;
   logic              wr;
   logic [NPINS-1:0]  level;
   logic [NPINS-1:0]  rise_en;
   logic [NPINS-1:0]  fall_en;
   logic [NPINS-1:0]  status;
   logic              unused_lsb;

   assign unused_lsb = ^bus_addr[1:0];
   assign kind    = reg_kind_e'(bus_addr[KIND_LSB +: KIND_W]);
   assign word    = bus_addr[2 +: WSEL_W];
   assign addr_ok = ((bus_addr >> TOP_LSB) == '0) && (kind != K_RSVD);
   assign wr      = bus_we && addr_ok;

   pinbank_sync #(.W(NPINS), .STAGES(STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pad_in),
      .dout  (level)
   );

   pinbank_outbank #(.NPINS(NPINS), .DW(DW)) u_outbank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_we  (wr && kind == K_SET),
      .clr_we  (wr && kind == K_CLR),
      .dir_we  (wr && kind == K_DIR),
      .wr_word (word),
      .wdata   (bus_wdata),
      .latch   (pad_out),
      .dir     (pad_oe)
   );

   pinbank_edge #(.NPINS(NPINS), .DW(DW)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .level   (level),
      .rise_we (wr && kind == K_RISE),
      .fall_we (wr && kind == K_FALL),
      .ack_we  (wr && kind == K_STAT),
      .wr_word (word),
      .wdata   (bus_wdata),
      .rise_en (rise_en),
      .fall_en (fall_en),
      .status  (status)
   );

   always_comb begin
      bus_rdata = '0;
      if (addr_ok) begin
         unique case (kind)
            K_LEVEL:      bus_rdata = level[int'(word)*DW +: DW];
            K_DIR:        bus_rdata = pad_oe[int'(word)*DW +: DW];
            K_SET, K_CLR: bus_rdata = pad_out[int'(word)*DW +: DW];
            K_RISE:       bus_rdata = rise_en[int'(word)*DW +: DW];
            K_FALL:       bus_rdata = fall_en[int'(word)*DW +: DW];
            K_STAT:       bus_rdata = status[int'(word)*DW +: DW];
            default:      bus_rdata = '0;
         endcase
      end
   end

   assign irq = |status;

   // the interrupt only drops after an acknowledge on the bus
   assert_irq_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(bus_we));
endmodule

// File: tb/pinbank_gpio_bench.sv
module pinbank_gpio_bench;
   localparam int OP_W = 2'd0;   // write addr <= data
   localparam int OP_R = 2'd1;   // read addr, compare with exp
   localparam int OP_P = 2'd2;   // set pad word (addr bit 2) to data, wait 3 cycles
   localparam int OP_I = 2'd3;   // compare irq with exp[0]
   localparam int NV = 45;

   localparam logic [73:0] VEC [NV] = '{
      {2'd0, 8'h10, 32'h0000_00F0, 32'h0},
      {2'd1, 8'h10, 32'h0, 32'h0000_00F0},
      {2'd1, 8'h18, 32'h0, 32'h0000_00F0},
      {2'd0, 8'h18, 32'h0000_0030, 32'h0},
      {2'd1, 8'h10, 32'h0, 32'h0000_00C0},
      {2'd0, 8'h14, 32'h8000_0001, 32'h0},
      {2'd1, 8'h14, 32'h0, 32'h8000_0001},
      {2'd1, 8'h10, 32'h0, 32'h0000_00C0},
      {2'd0, 8'h08, 32'h0000_FFFF, 32'h0},
      {2'd1, 8'h08, 32'h0, 32'h0000_FFFF},
      {2'd0, 8'h0C, 32'h0000_0001, 32'h0},
      {2'd1, 8'h0C, 32'h0, 32'h0000_0001},
      {2'd0, 8'h00, 32'hFFFF_FFFF, 32'h0},
      {2'd1, 8'h00, 32'h0, 32'h0000_0000},
      {2'd0, 8'h20, 32'h0000_0003, 32'h0},
      {2'd0, 8'h28, 32'h0000_0006, 32'h0},
      {2'd1, 8'h20, 32'h0, 32'h0000_0003},
      {2'd1, 8'h28, 32'h0, 32'h0000_0006},
      {2'd3, 8'h00, 32'h0, 32'h0},
      {2'd2, 8'h00, 32'h0000_0007, 32'h0},
      {2'd1, 8'h00, 32'h0, 32'h0000_0007},
      {2'd1, 8'h30, 32'h0, 32'h0000_0003},
      {2'd3, 8'h00, 32'h0, 32'h1},
      {2'd0, 8'h30, 32'h0000_0001, 32'h0},
      {2'd1, 8'h30, 32'h0, 32'h0000_0002},
      {2'd2, 8'h00, 32'h0000_0000, 32'h0},
      {2'd1, 8'h30, 32'h0, 32'h0000_0006},
      {2'd0, 8'h30, 32'hFFFF_FFFF, 32'h0},
      {2'd1, 8'h30, 32'h0, 32'h0000_0000},
      {2'd3, 8'h00, 32'h0, 32'h0},
      {2'd0, 8'h24, 32'h8000_0000, 32'h0},
      {2'd2, 8'h04, 32'h8000_0000, 32'h0},
      {2'd1, 8'h04, 32'h0, 32'h8000_0000},
      {2'd1, 8'h34, 32'h0, 32'h8000_0000},
      {2'd3, 8'h00, 32'h0, 32'h1},
      {2'd0, 8'h34, 32'h0000_0000, 32'h0},
      {2'd1, 8'h34, 32'h0, 32'h8000_0000},
      {2'd0, 8'h34, 32'h8000_0000, 32'h0},
      {2'd1, 8'h34, 32'h0, 32'h0000_0000},
      {2'd3, 8'h00, 32'h0, 32'h0},
      {2'd0, 8'h38, 32'hFFFF_FFFF, 32'h0},
      {2'd1, 8'h38, 32'h0, 32'h0000_0000},
      {2'd1, 8'h3C, 32'h0, 32'h0000_0000},
      {2'd1, 8'hFC, 32'h0, 32'h0000_0000},
      {2'd1, 8'h08, 32'h0, 32'h0000_FFFF}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] pad_in = '0;
   logic [63:0] pad_out;
   logic [63:0] pad_oe;
   logic        irq;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   pinbank_gpio u_pinbank_gpio (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .irq       (irq)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input string req, input logic [7:0] a, input logic [31:0] e);
      @(negedge clk);
      bus_addr = a;
      #1 check(req, {32'h0, bus_rdata}, {32'h0, e});
   endtask

   task automatic set_pads(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      if (a[2]) pad_in[63:32] = d; else pad_in[31:0] = d;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state of every register word and output
      for (int k = 0; k < 14; k++) bus_read("R11 reset reg", 8'(k * 4), 32'h0);
      #1 check("R11 reset irq", {63'h0, irq}, 64'h0);
      check("R11 reset pad_out", pad_out, 64'h0);
      check("R11 reset pad_oe", pad_oe, 64'h0);

      // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R10 R12
      for (int i = 0; i < NV; i++) begin
         logic [1:0]  op;
         logic [7:0]  a;
         logic [31:0] d;
         logic [31:0] e;
         {op, a, d, e} = VEC[i];
         case (int'(op))
            OP_W: bus_write(a, d);
            OP_R: bus_read($sformatf("R1-map vec %0d", i), a, e);
            OP_P: set_pads(a, d);
            OP_I: begin
               @(negedge clk);
               #1 check($sformatf("R10 irq vec %0d", i), {63'h0, irq}, {63'h0, e[0]});
            end
            default: ;
         endcase
      end

      // R2 and R4: pad-side view of latch and direction
      @(negedge clk);
      check("R2 pad_out", pad_out, 64'h8000_0001_0000_00C0);
      check("R4 pad_oe", pad_oe, 64'h0000_0001_0000_FFFF);

      // R9: a clearing write on the same edge as a new detection
      bus_write(8'h20, 32'h0000_0020);
      set_pads(8'h00, 32'h0000_0020);
      bus_read("R6 pin5 rise", 8'h30, 32'h0000_0020);
      set_pads(8'h00, 32'h0000_0000);
      bus_read("R7 pin5 fall disabled", 8'h30, 32'h0000_0020);
      @(negedge clk);
      pad_in[5] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_addr = 8'h30; bus_wdata = 32'h0000_0020; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      #1 check("R9 edge beats clear", {32'h0, bus_rdata}, 64'h20);
      bus_write(8'h30, 32'h0000_0020);
      bus_read("R8 plain clear", 8'h30, 32'h0);
      @(negedge clk);
      #1 check("R10 irq low", {63'h0, irq}, 64'h0);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule